// File: doc/BRIEF.md
# Misaligned Access Byte-Mask Splitter

This block takes one load or store request, given as a full byte address and an access length in bytes, and turns it into byte-enable maps for at most two aligned memory lines. The low address bits give the byte offset inside a line and the upper bits give the line number. The length becomes a run of ones starting at bit 0. That run is moved up by the offset. Ones that still fit inside the line form the first map. Ones that pass the line end form the second map, which belongs to the next line up.

The result is captured in an output register while a load-enable input is high, and held while it is low. A request that stays inside one line leaves the second map empty and its valid flag clear. A request that straddles a boundary sets the flag. Downstream logic then issues two line-sized accesses, one with each map.

Top module: `misalign_split`

## Requirements
- R1: While reset is active, and after it until the first capture, every output is zero.
- R2: One clock edge after a capture, `line0_o` equals the address bits above the offset field (address divided by 2^OFS_W).
- R3: Bit p of `mask0_o` enables byte p of the first line, with bit 0 being byte 0. It is set exactly when offset <= p < offset + length and p < 2^OFS_W.
- R4: Bit q of `mask1_o` enables byte q of the next line. It is set exactly when q < offset + length - 2^OFS_W. For example, address 0x5B with length 8 gives `mask0_o` 0xF800 and `mask1_o` 0x0007.
- R5: `line1_o` equals `line0_o` plus one, wrapping modulo 2^(ADDR_W-OFS_W). For example, line 63 is followed by line 0.
- R6: `second_vld_o` is 1 exactly when `mask1_o` is nonzero.
- R7: A length of zero gives two all-zero maps and a clear `second_vld_o`.
- R8: A length above MAX_LEN (default 8) is treated as MAX_LEN.
- R9: Outputs take the new request on the first rising edge where `ld_en_i` is 1. They keep their value on every edge where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en_i | input | 1 | Capture the current request on this edge |
| addr_i | input | ADDR_W | Full byte address of the access |
| len_i | input | OFS_W | Access length in bytes |
| line0_o | output | ADDR_W-OFS_W | Line holding the first byte |
| mask0_o | output | 2^OFS_W | Byte enables for the first line |
| line1_o | output | ADDR_W-OFS_W | Following line, wrapped |
| mask1_o | output | 2^OFS_W | Byte enables spilling into the following line |
| second_vld_o | output | 1 | The following line is touched |

## Verification
The assertions assume that `ld_en_i`, `addr_i` and `len_i` are known and stable around each rising edge. They judge each capture against the values of these inputs one edge earlier. The bench changes every input only on falling edges, so this assumption always holds. The bench deliberately includes lengths above the limit, because the clamp makes them defined. The stimulus covers offsets near the end of a line, the last line of the address space, zero lengths and idle cycles where the load enable is low.

// File: rtl/misalign_split_pkg.sv
package misalign_split_pkg;
    localparam int DEF_ADDR_W  = 10;
    localparam int DEF_OFS_W   = 4;
    localparam int DEF_MAX_LEN = 8;
endpackage

// File: rtl/len_to_unary.sv
module len_to_unary #(
    parameter int LEN_W   = 4,
    parameter int OUT_W   = 16,
    parameter int MAX_LEN = 8
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [OUT_W-1:0] unary_o
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] len_c;

    always_comb begin
        len_c = (len_i > LIMIT) ? LIMIT : len_i;
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign unary_o[i] = (LEN_W'(i) < len_c);
    end
endmodule

// File: rtl/mask_shifter.sv
module mask_shifter #(
    parameter int OFS_W = 4
) (
    input  logic [(1<<OFS_W)-1:0] unary_i,
    input  logic [OFS_W-1:0]      ofs_i,
    output logic [(1<<OFS_W)-1:0] lo_o,
    output logic [(1<<OFS_W)-1:0] hi_o
);
    localparam int LB = 1 << OFS_W;

    logic [2*LB-1:0] wide;

    always_comb begin
        wide = {{LB{1'b0}}, unary_i} << ofs_i;
        lo_o = wide[LB-1:0];
        hi_o = wide[2*LB-1:LB];
    end
endmodule

// File: rtl/misalign_split.sv
module misalign_split
    import misalign_split_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int OFS_W   = DEF_OFS_W,
    parameter int MAX_LEN = DEF_MAX_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [OFS_W-1:0]          len_i,
    output logic [ADDR_W-OFS_W-1:0]   line0_o,
    output logic [(1<<OFS_W)-1:0]     mask0_o,
    output logic [ADDR_W-OFS_W-1:0]   line1_o,
    output logic [(1<<OFS_W)-1:0]     mask1_o,
    output logic                      second_vld_o
);
    localparam int LB     = 1 << OFS_W;
    localparam int LINE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [LINE_W-1:0] line0;
        logic [LB-1:0]     mask0;
        logic [LINE_W-1:0] line1;
        logic [LB-1:0]     mask1;
        logic              vld1;
    } split_t;

    logic [LB-1:0] unary;
    logic [LB-1:0] lo_map;
    logic [LB-1:0] hi_map;
    split_t        st_d;
    split_t        st_q;

    len_to_unary #(
        .LEN_W   (OFS_W),
        .OUT_W   (LB),
        .MAX_LEN (MAX_LEN)
    ) u_unary (
        .len_i   (len_i),
        .unary_o (unary)
    );

    mask_shifter #(
        .OFS_W (OFS_W)
    ) u_shift (
        .unary_i (unary),
        .ofs_i   (addr_i[OFS_W-1:0]),
        .lo_o    (lo_map),
        .hi_o    (hi_map)
    );

    always_comb begin
        st_d = st_q;
        if (ld_en_i) begin
            st_d.line0 = addr_i[ADDR_W-1:OFS_W];
            st_d.line1 = addr_i[ADDR_W-1:OFS_W] + LINE_W'(1);
            st_d.mask0 = lo_map;
            st_d.mask1 = hi_map;
            st_d.vld1  = |hi_map;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line0_o      = st_q.line0;
    assign mask0_o      = st_q.mask0;
    assign line1_o      = st_q.line1;
    assign mask1_o      = st_q.mask1;
    assign second_vld_o = st_q.vld1;
endmodule

module misalign_split_chk #(
    parameter int ADDR_W  = 10,
    parameter int OFS_W   = 4,
    parameter int MAX_LEN = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ld_en_i,
    input logic [ADDR_W-1:0]       addr_i,
    input logic [OFS_W-1:0]        len_i,
    input logic [ADDR_W-OFS_W-1:0] line0_o,
    input logic [(1<<OFS_W)-1:0]   mask0_o,
    input logic [ADDR_W-OFS_W-1:0] line1_o,
    input logic [(1<<OFS_W)-1:0]   mask1_o,
    input logic                    second_vld_o
);
    localparam int LB = 1 << OFS_W;
    logic [OFS_W-1:0] len_lim;
    assign len_lim = (int'(len_i) > MAX_LEN) ? OFS_W'(MAX_LEN) : len_i;

    // R2: first line number taken from upper address bits
    assert_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i |=> line0_o == $past(addr_i[ADDR_W-1:OFS_W]));
    // R5: second line is the next line, wrapping
    assert_line1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i |=> line1_o == line0_o + 1'b1);
    // R6: flag agrees with the spill map
    assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        second_vld_o == (mask1_o != '0));
    // R8: enabled byte count equals the clamped length
    assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i |=> ($countones(mask0_o) + $countones(mask1_o)) == int'($past(len_lim)));
    // R4: a spill run joins the top byte of the first line
    assert_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        second_vld_o |-> (mask0_o[LB-1] && mask1_o[0]));
    // R9: nothing moves without a capture
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en_i |=> ($stable(mask0_o) && $stable(mask1_o) && $stable(line0_o)
                      && $stable(line1_o) && $stable(second_vld_o)));
endmodule

bind misalign_split misalign_split_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_W   (OFS_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_en_i      (ld_en_i),
    .addr_i       (addr_i),
    .len_i        (len_i),
    .line0_o      (line0_o),
    .mask0_o      (mask0_o),
    .line1_o      (line1_o),
    .mask1_o      (mask1_o),
    .second_vld_o (second_vld_o)
);

// File: tb/misalign_split_tb_top.sv
`timescale 1ns/1ps
module misalign_split_tb_top;
    localparam int ADDR_W = 10;
    localparam int OFS_W  = 4;
    localparam int LW     = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [OFS_W-1:0]  len_i = '0;
    logic [LW-1:0]     line0_o, line1_o;
    logic [15:0]       mask0_o, mask1_o;
    logic              second_vld_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  track = 0;
    bit  done = 0;

    int exp_l0 = 0, exp_l1 = 0, exp_m0 = 0, exp_m1 = 0, exp_v = 0;

    always #5 clk = ~clk;

    misalign_split dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en_i), .addr_i(addr_i), .len_i(len_i),
        .line0_o(line0_o), .mask0_o(mask0_o), .line1_o(line1_o), .mask1_o(mask1_o),
        .second_vld_o(second_vld_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: walk the bytes one at a time
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_l0 = 0; exp_l1 = 0; exp_m0 = 0; exp_m1 = 0; exp_v = 0;
        end else if (ld_en_i) begin
            int ofs, n;
            ofs = int'(addr_i) % 16;
            n   = (int'(len_i) > 8) ? 8 : int'(len_i);
            exp_l0 = int'(addr_i) / 16;
            exp_l1 = (exp_l0 + 1) % 64;
            exp_m0 = 0; exp_m1 = 0;
            for (int b = 0; b < n; b++) begin
                if (ofs + b < 16) exp_m0 |= (1 << (ofs + b));
                else              exp_m1 |= (1 << (ofs + b - 16));
            end
            exp_v = (exp_m1 != 0) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (track) begin
            chk("R2 line0", int'(line0_o), exp_l0);
            chk("R3 mask0", int'(mask0_o), exp_m0);
            chk("R4 mask1", int'(mask1_o), exp_m1);
            chk("R5 line1", int'(line1_o), exp_l1);
            chk("R6 second_vld", int'(second_vld_o), exp_v);
        end
    end

    task automatic issue(int a, int l, bit en);
        @(negedge clk);
        addr_i  = ADDR_W'(a);
        len_i   = OFS_W'(l);
        ld_en_i = en;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mask0", int'(mask0_o), 0);
        chk("R1 reset vld", int'(second_vld_o), 0);
        chk("R1 reset line1", int'(line1_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(mask0_o | mask1_o), 0);
        track = 1;

        issue(10'h05B, 8, 1);           // worked straddle case
        chk("R3 example map0", int'(mask0_o), 16'hF800);
        chk("R4 example map1", int'(mask1_o), 16'h0007);
        chk("R5 example line1", int'(line1_o), 6);

        issue(10'h040, 8, 1);           // aligned, single line
        chk("R6 aligned no spill", int'(second_vld_o), 0);
        chk("R3 aligned map0", int'(mask0_o), 16'h00FF);

        issue(10'h03F, 0, 1);           // zero length at line end
        chk("R7 zero len map0", int'(mask0_o), 0);
        chk("R7 zero len map1", int'(mask1_o), 0);
        chk("R7 zero len vld", int'(second_vld_o), 0);

        issue(10'h3FF, 4, 1);           // last line wraps
        chk("R5 wrap line1", int'(line1_o), 0);
        chk("R4 wrap map1", int'(mask1_o), 16'h0007);

        issue(10'h000, 15, 1);          // over-long length clamps
        chk("R8 clamp map0", int'(mask0_o), 16'h00FF);

        issue(10'h0A9, 15, 1);          // clamp with spill: ofs 9
        chk("R8 clamp spill map1", int'(mask1_o), 16'h0001);

        issue(10'h123, 5, 0);           // no capture
        chk("R9 hold map1", int'(mask1_o), 16'h0001);
        chk("R9 hold line0", int'(line0_o), 10);

        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            addr_i  = ADDR_W'($urandom);
            len_i   = OFS_W'($urandom_range(0, 12));
            ld_en_i = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        ld_en_i = 1'b0;
        @(negedge clk);
        track = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule